// File: doc/BRIEF.md
# Low-Power Entry and Wakeup Controller

This block decides when a processor subsystem may drop into a clock-gated sleep state and when it must come back out. Software first writes an 8-bit control byte that arms the feature and sets a 4-bit wakeup threshold. Later the processor halts and raises its stopped status. If the feature is armed, the block raises a sleep request toward the external clock logic.

While asleep, the block watches the interrupt side. That side presents the highest pending unmasked request as a valid flag and a 4-bit priority. A request whose priority is strictly above the threshold wakes the block. The block then drops its sleep request and gives a one-cycle wake pulse, so the clock logic can restart the clocks. The block goes back to its running state once the processor clears its stopped status.

The compare is also brought out as a purely combinational wake hint, so clock logic can act on it while the clocks are gated. The register port is a single-cycle strobe interface with no back-pressure. A write is taken on the clock edge where the strobe is high, and reads are combinational. The interrupt inputs are a level-sensitive status pair with no handshake, and the block never stalls them.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, and both enter_lp and exit_lp are low.
- R2: The control byte sits at offset 0x0F. Bit 7 is the arm bit and bits 3:0 are the wakeup threshold. Bits 6:4 always read 0. Reads at any other offset return 0, and writes at any other offset change nothing.
- R3: enter_lp rises on the clock edge after one where cpu_stopped is high and the arm bit is 1. With the arm bit at 0, a stop never raises enter_lp.
- R4: While asleep, a request with irq_valid low never causes a wakeup, whatever its priority.
- R5: While asleep, a request whose irq_prio equals the threshold keeps the block asleep. A request whose irq_prio is greater than the threshold wakes it on the next edge.
- R6: On wakeup, exit_lp is high for exactly one cycle, and enter_lp falls on the same edge that raises exit_lp.
- R7: After wakeup, or while asleep without a wakeup, the block returns to the running state on the edge after cpu_stopped goes low. It can then enter sleep again.
- R8: Writes to the control byte while enter_lp is high are ignored, so the threshold in force during sleep cannot change.
- R9: wake_pending is a combinational output that equals irq_valid AND (irq_prio > threshold) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken on the clock edge |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| cpu_stopped | input | 1 | Processor reports it has halted |
| irq_valid | input | 1 | An unmasked request is pending |
| irq_prio | input | 4 | Priority of the highest pending unmasked request |
| wake_pending | output | 1 | Combinational threshold-compare result |
| enter_lp | output | 1 | Sleep request to the clock logic |
| exit_lp | output | 1 | One-cycle wake pulse to the clock logic |

## Verification
The assertions assume that cpu_stopped stays high for as long as the block is asleep, unless software deliberately cancels the stop. They also assume the interrupt pair is held stable between clock edges, because the block samples it only at edges. The stimulus changes every input only on the falling clock edge. It keeps irq_valid low except during the wake phase of each sequence, and it lowers cpu_stopped only after the wake pulse has been checked or when testing a cancelled sleep. Threshold and priority pairs cover both ends of the 4-bit range, the equal case, and the case just one above.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PRIO_W = 4;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } lp_state_t;
endpackage

// File: rtl/lpwr_cfg_reg.sv
module lpwr_cfg_reg #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PRIO_W     = 4,
  parameter int unsigned ARM_BIT    = 7,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hold,
  output logic [DATA_W-1:0] rdata,
  output logic              arm,
  output logic [PRIO_W-1:0] level
);
  localparam logic [DATA_W-1:0] LVL_MASK = DATA_W'((1 << PRIO_W) - 1);
  localparam logic [DATA_W-1:0] ARM_MASK = DATA_W'(1) << ARM_BIT;
  localparam logic [DATA_W-1:0] WR_MASK  = LVL_MASK | ARM_MASK;

  logic [DATA_W-1:0] ctrl_q;
  logic              hit;

  assign hit = (addr == REG_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && hit && !hold) begin
      ctrl_q <= wdata & WR_MASK;
    end
  end

  assign rdata = hit ? ctrl_q : '0;
  assign arm   = ctrl_q[ARM_BIT];
  assign level = ctrl_q[PRIO_W-1:0];

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(ctrl_q));

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~WR_MASK) == '0);

  assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == '0);
endmodule

// File: rtl/lpwr_wake_cmp.sv
module lpwr_wake_cmp #(
  parameter int unsigned PRIO_W = 4
) (
  input  logic              req_valid,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] level,
  output logic              hit
);
  always_comb begin
    hit = 1'b0;
    if (req_valid && (req_prio > level)) begin
      hit = 1'b1;
    end
  end

  always_comb begin
    if (!req_valid) begin
      assert_novalid_nohit_R4: assert (!hit);
    end
  end
endmodule

// File: rtl/lpwr_seq_fsm.sv
module lpwr_seq_fsm
  import lpwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stopped,
  input  logic wake_hit,
  output logic asleep,
  output logic wake_pulse
);
  lp_state_t state_q, state_d;
  logic      pulse_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (stopped && arm) state_d = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_hit)      state_d = ST_WAKE;
        else if (!stopped) state_d = ST_RUN;
      end
      ST_WAKE:  if (!stopped) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_q == ST_SLEEP) && wake_hit;
    end
  end

  assign asleep     = (state_q == ST_SLEEP);
  assign wake_pulse = pulse_q;

  assert_enter_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(stopped && arm));

  assert_exit_onecycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_exit_from_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!asleep && $past(asleep)));

  assert_return_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && !stopped) |=> state_q == ST_RUN);
endmodule

// File: rtl/lpwr_wake_ctrl.sv
module lpwr_wake_ctrl
  import lpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_stopped,
  input  logic              irq_valid,
  input  logic [PRIO_W-1:0] irq_prio,
  output logic              wake_pending,
  output logic              enter_lp,
  output logic              exit_lp
);
  logic              arm;
  logic [PRIO_W-1:0] level;
  logic              hit;

  lpwr_cfg_reg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W),
    .ARM_BIT(DATA_W-1), .REG_OFFSET(ADDR_W'(15))
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .hold(enter_lp), .rdata(bus_rdata),
    .arm(arm), .level(level)
  );

  lpwr_wake_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .req_valid(irq_valid), .req_prio(irq_prio), .level(level), .hit(hit)
  );

  lpwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stopped(cpu_stopped),
    .wake_hit(hit), .asleep(enter_lp), .wake_pulse(exit_lp)
  );

  assign wake_pending = hit;

  assert_exit_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exit_lp |-> $past(irq_valid));

  assert_exit_strict_gt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_lp |-> $past(irq_prio > level));

  assert_equal_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_lp && irq_prio == level && cpu_stopped) |=> enter_lp);
endmodule

// File: tb/tb_lpwr_wake_ctrl.sv
module tb_lpwr_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_stopped = 1'b0;
  logic       irq_valid = 1'b0;
  logic [3:0] irq_prio = 4'h0;
  logic       wake_pending, enter_lp, exit_lp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lpwr_wake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stopped(cpu_stopped),
    .irq_valid(irq_valid), .irq_prio(irq_prio), .wake_pending(wake_pending),
    .enter_lp(enter_lp), .exit_lp(exit_lp)
  );

  // {valid, expect_wake, level[3:0], prio[3:0]}
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 1'b0, 4'd5,  4'd5 },
    {1'b1, 1'b1, 4'd5,  4'd6 },
    {1'b1, 1'b0, 4'd15, 4'd15},
    {1'b1, 1'b1, 4'd0,  4'd1 },
    {1'b1, 1'b0, 4'd0,  4'd0 },
    {1'b0, 1'b0, 4'd2,  4'd15},
    {1'b1, 1'b1, 4'd14, 4'd15},
    {1'b1, 1'b0, 4'd9,  4'd3 }
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'hF;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    bus_addr = 4'hF;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'hF, 8'h00, "R1 reset byte");
    chk(enter_lp == 1'b0, "R1 enter after reset", enter_lp, 0);
    chk(exit_lp == 1'b0, "R1 exit after reset", exit_lp, 0);

    // table walk: R3 R5 R4 R6 R7 R9
    for (int i = 0; i < 8; i++) begin
      logic v, e;
      logic [3:0] lv, pr;
      {v, e, lv, pr} = VEC[i];
      wr(4'hF, {1'b1, 3'b000, lv});
      cpu_stopped = 1'b1;
      @(negedge clk);
      chk(enter_lp == 1'b1, "R3 enter when armed", enter_lp, 1);
      irq_valid = v; irq_prio = pr;
      #1;
      chk(wake_pending == e, "R9 wake_pending compare", wake_pending, e);
      @(negedge clk);
      chk(exit_lp == e, "R5 exit vs threshold (R4 when invalid)", exit_lp, e);
      chk(enter_lp == !e, "R6 enter drops on wake", enter_lp, !e);
      if (e) begin
        @(negedge clk);
        chk(exit_lp == 1'b0, "R6 exit one cycle", exit_lp, 0);
      end
      irq_valid = 1'b0; irq_prio = 4'h0; cpu_stopped = 1'b0;
      @(negedge clk);
      chk(enter_lp == 1'b0 && exit_lp == 1'b0, "R7 back to run", {enter_lp, exit_lp}, 0);
    end

    // R2 field layout and decode
    wr(4'hF, 8'hFF);
    rd(4'hF, 8'h8F, "R2 reserved bits zero");
    wr(4'h3, 8'h00);
    rd(4'hF, 8'h8F, "R2 other offset write ignored");
    rd(4'h3, 8'h00, "R2 other offset reads zero");

    // R3 no entry while disarmed
    wr(4'hF, 8'h03);
    cpu_stopped = 1'b1;
    repeat (2) @(negedge clk);
    chk(enter_lp == 1'b0, "R3 no entry when disarmed", enter_lp, 0);
    irq_valid = 1'b1; irq_prio = 4'd9;
    @(negedge clk);
    chk(exit_lp == 1'b0, "R3 no exit without sleep", exit_lp, 0);
    irq_valid = 1'b0; cpu_stopped = 1'b0;
    @(negedge clk);

    // R8 write during sleep ignored
    wr(4'hF, 8'h85);
    cpu_stopped = 1'b1;
    @(negedge clk);
    chk(enter_lp == 1'b1, "R8 setup sleep", enter_lp, 1);
    wr(4'hF, 8'h8A);
    rd(4'hF, 8'h85, "R8 byte unchanged in sleep");
    irq_valid = 1'b1; irq_prio = 4'd6;
    @(negedge clk);
    chk(exit_lp == 1'b1, "R8 old threshold still used", exit_lp, 1);
    irq_valid = 1'b0; cpu_stopped = 1'b0;
    @(negedge clk);

    // R7 cancelled sleep then re-entry
    cpu_stopped = 1'b1;
    @(negedge clk);
    chk(enter_lp == 1'b1, "R7 enter again", enter_lp, 1);
    cpu_stopped = 1'b0;
    @(negedge clk);
    chk(enter_lp == 1'b0 && exit_lp == 1'b0, "R7 cancel sleep", {enter_lp, exit_lp}, 0);
    cpu_stopped = 1'b1;
    @(negedge clk);
    chk(enter_lp == 1'b1, "R7 re-entry", enter_lp, 1);
    cpu_stopped = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule